// File: doc/BRIEF.md
# ADC Scan Phase Sequencer

This block sets the timing of a multi-channel successive-approximation A/D scan. It waits for a start request from software, from a synchronous timer event or from an asynchronous external event. It then steps through a fixed series of phases: start processing, an optional shared sample-and-hold capture, an optional self-diagnosis conversion, one sampling window and one conversion window for each selected channel, and end processing. For each phase it raises a strobe. It also presents the channel being worked on, a busy flag and a one-cycle done pulse.

The analog converter is not modelled. A conversion is a window of fixed length, and at the end of that window the block emits a stub result that carries the channel index. The design runs on a single clock. Each term counted in bus clocks is stretched by the parameter `BUS_RATIO`. The configuration inputs must be held steady while a scan is running.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is idle: busy, done, res_valid and every phase strobe are low. At most one of ph_start, ph_sh, ph_samp, ph_conv and ph_end is ever high.
- R2: A trigger taken while idle raises ph_start on the next cycle, and ph_start stays high for L cycles. With B = BUS_RATIO, L is: software 4, or 6 when diagnosis runs first; synchronous 2B+4, or 2B+6 when diagnosis runs first; asynchronous 2B+4, or 4B+6 when diagnosis runs first. When several triggers arrive together, software wins over synchronous, and synchronous wins over asynchronous.
- R3: A channel's sampling phase lasts samp_cfg[c*CW +: CW] cycles, and a value of 0 counts as 1. The top channel (index NCH-1) is the internal reference, and it always samples for 15 cycles.
- R4: Each conversion lasts exactly 32 cycles. Channels whose ch_mask bit is 1 are converted in ascending index order. res_valid pulses on the last conversion cycle, and res_data then equals the channel index.
- R5: When sh_en is 1 and ch_mask shares a bit with sh_mask, ph_sh is high for sh_samp cycles (0 counts as 1) and then for a 13-cycle wait, both after start processing. After the last channel it is high again for 3 cycles. The held channels (sh_en and sh_mask[c] both 1) skip their own sampling phase.
- R6: With diag_en=1 and diag_after=0, a diagnosis conversion runs before the first channel. It consists of diag_samp sampling cycles (0 counts as 1) and 32 conversion cycles, with diag_act high throughout, followed by a 2-cycle gap.
- R7: With diag_en=1 and diag_after=1, a 2-cycle gap follows the last channel, and the diagnosis conversion runs after that gap.
- R8: When dis_cnt is non-zero, a phase of dis_cnt cycles comes before each channel's sampling or conversion. When dis_cnt is 0, that phase is skipped.
- R9: ph_end lasts BUS_RATIO+3 cycles. On the cycle after it, busy is low and done is high for exactly one cycle.
- R10: With an all-zero mask, and with diagnosis and sample-and-hold off, the busy time is only start processing plus end processing.
- R11: A trigger that arrives while busy has no effect: the scan length is unchanged and no new scan follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_sw | input | 1 | Software start request |
| trig_sync | input | 1 | Synchronous timer start request |
| trig_async | input | 1 | Asynchronous external start request |
| ch_mask | input | NCH | Channels selected for the scan |
| samp_cfg | input | NCH*CW | Sampling length for each channel |
| sh_en | input | 1 | Enable for the shared sample-and-hold |
| sh_mask | input | NCH | Channels served by the sample-and-hold |
| sh_samp | input | CW | Sample-and-hold capture length |
| diag_en | input | 1 | Enable for the self-diagnosis conversion |
| diag_after | input | 1 | Run diagnosis after the channels instead of before |
| diag_samp | input | CW | Diagnosis sampling length |
| dis_cnt | input | 4 | Length of the disconnection-assist phase, 0 = none |
| ph_start | output | 1 | Start processing phase |
| ph_sh | output | 1 | Sample-and-hold capture, wait or end phase |
| ph_samp | output | 1 | Sampling phase (channel or diagnosis) |
| ph_conv | output | 1 | Conversion phase (channel or diagnosis) |
| ph_end | output | 1 | End processing phase |
| diag_act | output | 1 | Diagnosis sampling or conversion in progress |
| cur_ch | output | CHW | Channel being processed |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the scan ends |
| res_valid | output | 1 | Stub conversion result is valid |
| res_data | output | RES_W | Stub result (the channel index) |

## Verification
The hardest case to reach from the ports is the one where the options interact. Several combinations must be covered: diagnosis placed after the channels together with sample-and-hold on, a mask that holds only some of the held channels, and a mask that leaves only the reference channel. To reach them, the bench sweeps every mask over every trigger type, every diagnosis placement and both sample-and-hold settings. For each scan it counts the cycles of each strobe and checks those counts, and the total busy time, against sums computed in closed form. Separate scans cover a zero sampling setting, non-zero disconnection assist, simultaneous triggers and a trigger pulsed in the middle of a scan.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH       = 4,
  parameter int CW        = 8,
  parameter int BUS_RATIO = 1,
  parameter int CONV_CYC  = 32,
  parameter int REF_SAMP  = 15,
  parameter int SH_WAIT   = 13,
  parameter int SH_END    = 3,
  parameter int DIAG_GAP  = 2,
  parameter int RES_W     = 12,
  localparam int CHW      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_sw,
  input  logic              trig_sync,
  input  logic              trig_async,
  input  logic [NCH-1:0]    ch_mask,
  input  logic [NCH*CW-1:0] samp_cfg,
  input  logic              sh_en,
  input  logic [NCH-1:0]    sh_mask,
  input  logic [CW-1:0]     sh_samp,
  input  logic              diag_en,
  input  logic              diag_after,
  input  logic [CW-1:0]     diag_samp,
  input  logic [3:0]        dis_cnt,
  output logic              ph_start,
  output logic              ph_sh,
  output logic              ph_samp,
  output logic              ph_conv,
  output logic              ph_end,
  output logic              diag_act,
  output logic [CHW-1:0]    cur_ch,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data
);
  localparam int CNT_W = CW + 5;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SHS, S_SHW, S_DGS, S_DGC, S_GAP, S_DIS, S_SMP, S_CNV, S_SHE, S_END
  } st_t;
  typedef enum logic [2:0] {K_NONE, K_PRE, K_FIRST, K_NEXT, K_TAIL, K_POST} stp_t;

  st_t st, n_st;
  logic [CNT_W-1:0] cnt, n_cnt, start_len;
  logic [CHW-1:0] ch, n_ch, ec, f_idx, n_idx;
  logic f_ok, n_ok, enter, done_q;
  stp_t stp;

  wire sh_act     = sh_en && |(ch_mask & sh_mask);
  wire diag_first = diag_en && !diag_after;
  wire trig_any   = trig_sw || trig_sync || trig_async;

  function automatic logic [CNT_W-1:0] len1(input logic [CW-1:0] v);
    return (v == '0) ? CNT_W'(1) : CNT_W'(v);
  endfunction

  function automatic logic [CNT_W-1:0] smp_len(input logic [CHW-1:0] c);
    logic [CW-1:0] v;
    v = samp_cfg[int'(c)*CW +: CW];
    return (int'(c) == NCH-1) ? CNT_W'(REF_SAMP) : len1(v);
  endfunction

  always_comb begin
    if (trig_sw)        start_len = CNT_W'(diag_first ? 6 : 4);
    else if (trig_sync) start_len = CNT_W'(2*BUS_RATIO + (diag_first ? 6 : 4));
    else                start_len = diag_first ? CNT_W'(4*BUS_RATIO + 6) : CNT_W'(2*BUS_RATIO + 4);
  end

  always_comb begin
    f_ok = 1'b0; f_idx = '0; n_ok = 1'b0; n_idx = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (ch_mask[i]) begin
        f_ok = 1'b1; f_idx = CHW'(i);
        if (i > int'(ch)) begin n_ok = 1'b1; n_idx = CHW'(i); end
      end
    end
  end

  always_comb begin
    n_st = st; n_cnt = cnt - 1'b1; n_ch = ch; stp = K_NONE; ec = ch; enter = 1'b0;
    if (st == S_IDLE) begin
      n_cnt = cnt;
      if (trig_any) begin n_st = S_START; n_cnt = start_len - 1'b1; end
    end else if (cnt == '0) begin
      case (st)
        S_START: if (sh_act) begin n_st = S_SHS; n_cnt = len1(sh_samp) - 1'b1; end
                 else stp = K_PRE;
        S_SHS:   begin n_st = S_SHW; n_cnt = CNT_W'(SH_WAIT - 1); end
        S_SHW:   stp = K_PRE;
        S_DGS:   begin n_st = S_DGC; n_cnt = CNT_W'(CONV_CYC - 1); end
        S_DGC:   if (diag_after) stp = K_POST;
                 else begin n_st = S_GAP; n_cnt = CNT_W'(DIAG_GAP - 1); end
        S_GAP:   if (diag_after) begin n_st = S_DGS; n_cnt = len1(diag_samp) - 1'b1; end
                 else stp = K_FIRST;
        S_DIS:   if (sh_en && sh_mask[ch]) begin n_st = S_CNV; n_cnt = CNT_W'(CONV_CYC - 1); end
                 else begin n_st = S_SMP; n_cnt = smp_len(ch) - 1'b1; end
        S_SMP:   begin n_st = S_CNV; n_cnt = CNT_W'(CONV_CYC - 1); end
        S_CNV:   stp = K_NEXT;
        S_SHE:   begin n_st = S_END; n_cnt = CNT_W'(BUS_RATIO + 2); end
        default: begin n_st = S_IDLE; n_cnt = '0; end
      endcase
      if (stp == K_PRE) begin
        if (diag_first) begin n_st = S_DGS; n_cnt = len1(diag_samp) - 1'b1; end
        else stp = K_FIRST;
      end
      if (stp == K_FIRST) begin
        if (f_ok) begin enter = 1'b1; ec = f_idx; end else stp = K_TAIL;
      end
      if (stp == K_NEXT) begin
        if (n_ok) begin enter = 1'b1; ec = n_idx; end else stp = K_TAIL;
      end
      if (stp == K_TAIL) begin
        if (diag_en && diag_after) begin n_st = S_GAP; n_cnt = CNT_W'(DIAG_GAP - 1); end
        else stp = K_POST;
      end
      if (stp == K_POST) begin
        if (sh_act) begin n_st = S_SHE; n_cnt = CNT_W'(SH_END - 1); end
        else begin n_st = S_END; n_cnt = CNT_W'(BUS_RATIO + 2); end
      end
      if (enter) begin
        n_ch = ec;
        if (dis_cnt != 4'd0) begin n_st = S_DIS; n_cnt = CNT_W'(dis_cnt) - 1'b1; end
        else if (sh_en && sh_mask[ec]) begin n_st = S_CNV; n_cnt = CNT_W'(CONV_CYC - 1); end
        else begin n_st = S_SMP; n_cnt = smp_len(ec) - 1'b1; end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ch <= '0; done_q <= 1'b0;
    end else begin
      st <= n_st; cnt <= n_cnt; ch <= n_ch;
      done_q <= (st == S_END) && (cnt == '0);
    end
  end

  assign ph_start  = st == S_START;
  assign ph_sh     = st == S_SHS || st == S_SHW || st == S_SHE;
  assign ph_samp   = st == S_SMP || st == S_DGS;
  assign ph_conv   = st == S_CNV || st == S_DGC;
  assign ph_end    = st == S_END;
  assign diag_act  = st == S_DGS || st == S_DGC;
  assign cur_ch    = ch;
  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign res_valid = st == S_CNV && cnt == '0;
  assign res_data  = RES_W'(ch);
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_mask,
  input logic           ph_start,
  input logic           ph_sh,
  input logic           ph_samp,
  input logic           ph_conv,
  input logic           ph_end,
  input logic           diag_act,
  input logic [CHW-1:0] cur_ch,
  input logic           busy,
  input logic           done,
  input logic           res_valid
);
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_start, ph_sh, ph_samp, ph_conv, ph_end})); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(ph_start || ph_sh || ph_samp || ph_conv || ph_end || res_valid)); // R1
  AST_RISE_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ph_start); // R2
  AST_RES_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (ph_conv && !diag_act && ch_mask[cur_ch])); // R4
  AST_CONV_CH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_conv && !diag_act && $past(ph_conv) && !$past(diag_act) && !$past(res_valid)) |-> $stable(cur_ch)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(ph_end))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ph_start) |=> !ph_start); // R11
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .CHW(CHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .ph_start(ph_start), .ph_sh(ph_sh),
  .ph_samp(ph_samp), .ph_conv(ph_conv), .ph_end(ph_end), .diag_act(diag_act),
  .cur_ch(cur_ch), .busy(busy), .done(done), .res_valid(res_valid)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
  localparam int NCH = 4, CW = 8, R = 1, CHW = 2, RES_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_sw = 0, trig_sync = 0, trig_async = 0;
  logic [NCH-1:0] ch_mask = '0, sh_mask = 4'b0011;
  logic [NCH*CW-1:0] samp_cfg;
  logic sh_en = 0, diag_en = 0, diag_after = 0;
  logic [CW-1:0] sh_samp = 8'd4, diag_samp = 8'd5;
  logic [3:0] dis_cnt = 0;
  logic ph_start, ph_sh, ph_samp, ph_conv, ph_end, diag_act, busy, done, res_valid;
  logic [CHW-1:0] cur_ch;
  logic [RES_W-1:0] res_data;
  int n_chk = 0, n_fail = 0;
  int samp_v [NCH] = '{2, 3, 4, 9};

  always #4 clk = ~clk;

  adc_scan_seq #(.NCH(NCH), .CW(CW), .BUS_RATIO(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_sw(trig_sw), .trig_sync(trig_sync), .trig_async(trig_async),
    .ch_mask(ch_mask), .samp_cfg(samp_cfg), .sh_en(sh_en), .sh_mask(sh_mask), .sh_samp(sh_samp),
    .diag_en(diag_en), .diag_after(diag_after), .diag_samp(diag_samp), .dis_cnt(dis_cnt),
    .ph_start(ph_start), .ph_sh(ph_sh), .ph_samp(ph_samp), .ph_conv(ph_conv), .ph_end(ph_end),
    .diag_act(diag_act), .cur_ch(cur_ch), .busy(busy), .done(done), .res_valid(res_valid),
    .res_data(res_data));

  always_comb for (int i = 0; i < NCH; i++) samp_cfg[i*CW +: CW] = CW'(samp_v[i]);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tt: 0 software, 1 synchronous, 2 asynchronous, 3 all three together; dm: 0 off, 1 first, 2 after
  task automatic run_scan(input int tt, input logic [3:0] m, input int dm, input bit sh,
                          input int dis, input bit inject);
    int l, tot, smp, shx, pop, bsy, nst, nsh, nsm, ncv, nen, nres, prev, guard;
    bit df, shact;
    ch_mask = m; sh_en = sh; diag_en = (dm != 0); diag_after = (dm == 2); dis_cnt = 4'(dis);
    df = (dm == 1);
    shact = sh && ((m & sh_mask) != 0);
    case (tt)
      1:       l = 2*R + (df ? 6 : 4);
      2:       l = df ? 4*R + 6 : 2*R + 4;
      default: l = df ? 6 : 4;
    endcase
    pop = 0; smp = (dm != 0) ? diag_samp : 0;
    shx = shact ? ((sh_samp == 0 ? 1 : sh_samp) + 13 + 3) : 0;
    tot = l + shx + ((dm != 0) ? diag_samp + 32 + 2 : 0) + R + 3;
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      pop++;
      tot += dis + 32;
      if (!(sh && sh_mask[c])) begin
        int s;
        s = (c == NCH-1) ? 15 : (samp_v[c] == 0 ? 1 : samp_v[c]);
        tot += s; smp += s;
      end
    end
    trig_sw = (tt == 0 || tt == 3); trig_sync = (tt == 1 || tt == 3); trig_async = (tt >= 2);
    @(negedge clk);
    trig_sw = 0; trig_sync = 0; trig_async = 0;
    bsy = 0; nst = 0; nsh = 0; nsm = 0; ncv = 0; nen = 0; nres = 0; prev = -1; guard = 0;
    while (!done && guard < 3000) begin
      if (inject) trig_sw = 0;
      bsy += busy; nst += ph_start; nsh += ph_sh; nsm += ph_samp; ncv += ph_conv; nen += ph_end;
      if (res_valid) begin
        nres++;
        chk("R4 ascending order", int'(res_data) > prev, 1);
        chk("R4 result in mask", int'(m[res_data[CHW-1:0]]), 1);
        prev = int'(res_data);
      end
      if (inject && bsy == 6) trig_sw = 1;
      guard++;
      @(negedge clk);
    end
    trig_sw = 0;
    if (guard >= 3000) chk("R9 scan finished", 0, 1);
    chk("R2 start length", nst, l);
    chk("R3 R6 sampling cycles", nsm, smp);
    chk("R4 conversion cycles", ncv, 32*(pop + (dm != 0)));
    chk("R4 result count", nres, pop);
    chk("R5 sample-and-hold cycles", nsh, shx);
    chk("R9 end length", nen, R + 3);
    chk("R3 R5 R6 R7 R8 R11 busy total", bsy, tot);
    if (m == 0 && dm == 0 && !sh) chk("R10 empty mask busy", bsy, l + R + 3);
    chk("R9 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk("R9 done single pulse", int'(done), 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk("R11 no restart", int'(busy), 0);
    end
  endtask

  initial begin
    #(8*190000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 strobes at reset", int'({ph_start, ph_sh, ph_samp, ph_conv, ph_end, res_valid}), 0);
    chk("R1 done at reset", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    for (int tt = 0; tt < 3; tt++)
      for (int dm = 0; dm < 3; dm++)
        for (int sh = 0; sh < 2; sh++)
          for (int m = 0; m < 16; m++)
            run_scan(tt, 4'(m), dm, sh[0], 0, 0);
    run_scan(3, 4'b1111, 1, 0, 0, 0);
    run_scan(3, 4'b0101, 0, 0, 0, 0);
    run_scan(0, 4'b1111, 0, 0, 3, 0);
    run_scan(1, 4'b1011, 2, 1, 7, 0);
    samp_v[0] = 0;
    run_scan(0, 4'b0001, 0, 0, 0, 0);
    samp_v[0] = 2;
    run_scan(0, 4'b1111, 0, 0, 0, 1);
    run_scan(2, 4'b0110, 1, 1, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule